// File: doc/BRIEF.md
# Machine-Mode CSR Register File

This block is the control and status register bank of a 32-bit core that runs only at the machine privilege level. The execute stage presents a 12-bit register address, a two-bit operation code and a source operand. The bank returns the current register value in the same cycle and raises an illegal flag when the access cannot be honoured. Accepted writes take effect at the next clock edge.

The trap logic uses a separate side port. A trap-entry pulse saves the faulting PC and cause and closes the global interrupt gate. A trap-return pulse reopens the gate from the saved copy. Both pulses take priority over any register access in the same cycle.

The bank also holds:
- a free-running 64-bit cycle counter;
- fixed identification words, including a version word split into major and minor halves;
- a registered copy of the interrupt lines;
- a custom register with a single-step enable bit.

Top module: `mcsr_bank`

## Requirements
- R1: While reset is held, every writable register reads zero, the global interrupt enable and its saved copy are 0, the step bit is 0, and the cycle counter holds the value of parameter CYC_RESET.
- R2: Operation code 00 reads only, 01 writes the operand, 10 ORs the operand in, and 11 clears the operand's set bits. A set or clear with a zero operand performs no write.
- R3: Read data and the illegal flag are combinational from the current address and state. An accepted write is visible from the next cycle.
- R4: The illegal flag is raised for an access to an address that is not mapped. It is also raised for an access that would write one of the read-only words: 0x301, 0x311, 0x312, 0x313, 0x314, 0x344, 0xB00 and 0xB80. A flagged access changes no state.
- R5: The status word at 0x300 has a writable enable in bit 3 and a writable saved enable in bit 7. Bits 12:11 always read 11 and every other bit reads 0.
- R6: The word at 0x301 reads 0x40001100. Bit 12 reads 0 when parameter HAS_MUL is 0.
- R7: Addresses 0x311, 0x312 and 0x314 read zero. Address 0x313 reads the major version in bits 31:16 and the minor version in bits 15:0; the default is 0x00010014.
- R8: The enable register at 0x304 stores only bits 3, 7, 11 and 31:16 (the IRQ_MASK default 0xFFFF0888). All other bits read 0.
- R9: The exception PC at 0x341 always has bits 1:0 at zero, whether it is loaded by a CSR write or by trap entry.
- R10: Trap entry does four things at the next edge: it loads the exception PC from trap_pc with bits 1:0 cleared, loads the cause register at 0x342 from trap_cause, copies the enable bit into the saved bit, and clears the enable. Any CSR write in that cycle is dropped.
- R11: Trap return (without trap entry) copies the saved bit into the enable and sets the saved bit to 1. Any CSR write in that cycle is dropped.
- R12: The pending word at 0x344 reads irq_lines ANDed with IRQ_MASK as sampled at the previous clock edge.
- R13: The cycle counter increments on every clock edge out of reset, with the carry passing from the low to the high word. The low word reads at 0xB00 and the high word at 0xB80.
- R14: Only bit 0 of the register at 0x7C0 is stored; it drives step_en. The trap vector at 0x305 and the scratch word at 0x340 store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_addr | input | 12 | Register address |
| csr_src | input | 32 | Source operand |
| csr_rdata | output | 32 | Current value of the addressed register |
| csr_illegal | output | 1 | Access rejected |
| trap_enter | input | 1 | Trap taken this cycle |
| trap_return | input | 1 | Return from trap this cycle |
| trap_cause | input | 32 | Cause code saved on trap entry |
| trap_pc | input | 32 | PC saved on trap entry |
| irq_lines | input | 32 | Raw interrupt request lines |
| glb_ie | output | 1 | Global interrupt enable |
| ie_mask_o | output | 32 | Per-source enable register |
| tvec_o | output | 32 | Trap vector |
| epc_o | output | 32 | Exception PC |
| step_en | output | 1 | Single-step enable |

## Verification
The assertions assume that csr_op, csr_src and the trap port carry known values whenever csr_en or a trap pulse is high. They also assume that a trap pulse lasts one cycle per event. The stimulus drives every input to a defined value in every cycle and changes it only at the falling edge. Trap entry and trap return are each driven alone, except for one cycle in which both are raised to confirm that entry wins. Sweeps mix legal, read-only and unmapped addresses with zero and nonzero operands, so the no-write corners are reached from both sides.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STATUS, SEL_ISA, SEL_IE, SEL_TVEC, SEL_VENDOR,
        SEL_ARCH, SEL_IMP, SEL_HART, SEL_SCRATCH, SEL_EPC, SEL_CAUSE,
        SEL_PEND, SEL_CYC_LO, SEL_CYC_HI, SEL_STEP
    } csr_sel_e;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_IE      = 12'h304;
    localparam logic [11:0] A_TVEC    = 12'h305;
    localparam logic [11:0] A_VENDOR  = 12'h311;
    localparam logic [11:0] A_ARCH    = 12'h312;
    localparam logic [11:0] A_IMP     = 12'h313;
    localparam logic [11:0] A_HART    = 12'h314;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_PEND    = 12'h344;
    localparam logic [11:0] A_STEP    = 12'h7C0;
    localparam logic [11:0] A_CYC_LO  = 12'hB00;
    localparam logic [11:0] A_CYC_HI  = 12'hB80;

    typedef struct packed {
        logic        ie;
        logic        pie;
        logic [31:0] ie_reg;
        logic [31:0] tvec;
        logic [31:0] scratch;
        logic [31:0] epc;
        logic [31:0] cause;
        logic [31:0] pend;
        logic        step;
    } csr_state_t;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel,
    output logic        ro
);
    always_comb begin
        sel = SEL_NONE;
        unique case (addr)
            A_STATUS:  sel = SEL_STATUS;
            A_ISA:     sel = SEL_ISA;
            A_IE:      sel = SEL_IE;
            A_TVEC:    sel = SEL_TVEC;
            A_VENDOR:  sel = SEL_VENDOR;
            A_ARCH:    sel = SEL_ARCH;
            A_IMP:     sel = SEL_IMP;
            A_HART:    sel = SEL_HART;
            A_SCRATCH: sel = SEL_SCRATCH;
            A_EPC:     sel = SEL_EPC;
            A_CAUSE:   sel = SEL_CAUSE;
            A_PEND:    sel = SEL_PEND;
            A_STEP:    sel = SEL_STEP;
            A_CYC_LO:  sel = SEL_CYC_LO;
            A_CYC_HI:  sel = SEL_CYC_HI;
            default:   sel = SEL_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_ISA, SEL_VENDOR, SEL_ARCH, SEL_IMP, SEL_HART,
            SEL_PEND, SEL_CYC_LO, SEL_CYC_HI: ro = 1'b1;
            default:                          ro = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcsr_modify.sv
module mcsr_modify
    import mcsr_pkg::*;
#(
    parameter int W = 32
) (
    input  csr_op_e        op,
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   src,
    output logic [W-1:0]   new_val,
    output logic           wr_req
);
    localparam logic [W-1:0] ZERO = '0;

    always_comb begin
        new_val = old_val;
        wr_req  = 1'b0;
        unique case (op)
            OP_READ:  ;
            OP_WRITE: begin new_val = src;            wr_req = 1'b1;         end
            OP_SET:   begin new_val = old_val | src;  wr_req = (src != ZERO); end
            OP_CLEAR: begin new_val = old_val & ~src; wr_req = (src != ZERO); end
            default:  ;
        endcase
    end
endmodule

// File: rtl/mcsr_cycle.sv
module mcsr_cycle #(
    parameter int              CW        = 64,
    parameter logic [CW-1:0]   RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RESET_VAL;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R13
    cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/mcsr_bank.sv
module mcsr_bank
    import mcsr_pkg::*;
#(
    parameter bit           HAS_MUL   = 1'b1,
    parameter int           VER_MAJOR = 1,
    parameter int           VER_MINOR = 20,
    parameter logic [31:0]  IRQ_MASK  = 32'hFFFF_0888,
    parameter logic [63:0]  CYC_RESET = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_en,
    input  logic [1:0]  csr_op,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_src,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal,
    input  logic        trap_enter,
    input  logic        trap_return,
    input  logic [31:0] trap_cause,
    input  logic [31:0] trap_pc,
    input  logic [31:0] irq_lines,
    output logic        glb_ie,
    output logic [31:0] ie_mask_o,
    output logic [31:0] tvec_o,
    output logic [31:0] epc_o,
    output logic        step_en
);
    localparam int          XW       = 32;
    localparam int          CW       = 2 * XW;
    localparam logic [31:0] ISA_WORD = 32'h4000_0100 | (HAS_MUL ? 32'h0000_1000 : 32'h0);
    localparam logic [31:0] IMP_WORD = {VER_MAJOR[15:0], VER_MINOR[15:0]};

    csr_state_t     st_d, st_q;
    csr_sel_e       sel;
    logic           ro;
    logic [XW-1:0]  new_val;
    logic           wr_req;
    logic           write_ok;
    logic [CW-1:0]  cyc;

    mcsr_decode u_decode (
        .addr (csr_addr),
        .sel  (sel),
        .ro   (ro)
    );

    mcsr_modify #(.W(XW)) u_modify (
        .op      (csr_op_e'(csr_op)),
        .old_val (csr_rdata),
        .src     (csr_src),
        .new_val (new_val),
        .wr_req  (wr_req)
    );

    mcsr_cycle #(.CW(CW), .RESET_VAL(CYC_RESET)) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cyc)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:  csr_rdata = {19'b0, 2'b11, 3'b0, st_q.pie, 3'b0, st_q.ie, 3'b0};
            SEL_ISA:     csr_rdata = ISA_WORD;
            SEL_IE:      csr_rdata = st_q.ie_reg;
            SEL_TVEC:    csr_rdata = st_q.tvec;
            SEL_IMP:     csr_rdata = IMP_WORD;
            SEL_SCRATCH: csr_rdata = st_q.scratch;
            SEL_EPC:     csr_rdata = st_q.epc;
            SEL_CAUSE:   csr_rdata = st_q.cause;
            SEL_PEND:    csr_rdata = st_q.pend;
            SEL_CYC_LO:  csr_rdata = cyc[XW-1:0];
            SEL_CYC_HI:  csr_rdata = cyc[CW-1:XW];
            SEL_STEP:    csr_rdata = {31'b0, st_q.step};
            default:     csr_rdata = '0;
        endcase
    end

    assign csr_illegal = csr_en && ((sel == SEL_NONE) || (ro && wr_req));
    assign write_ok    = csr_en && wr_req && !csr_illegal && !trap_enter && !trap_return;

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_lines & IRQ_MASK;
        if (trap_enter) begin
            st_d.epc   = {trap_pc[XW-1:2], 2'b00};
            st_d.cause = trap_cause;
            st_d.pie   = st_q.ie;
            st_d.ie    = 1'b0;
        end else if (trap_return) begin
            st_d.ie  = st_q.pie;
            st_d.pie = 1'b1;
        end else if (write_ok) begin
            unique case (sel)
                SEL_STATUS: begin
                    st_d.ie  = new_val[3];
                    st_d.pie = new_val[7];
                end
                SEL_IE:      st_d.ie_reg  = new_val & IRQ_MASK;
                SEL_TVEC:    st_d.tvec    = new_val;
                SEL_SCRATCH: st_d.scratch = new_val;
                SEL_EPC:     st_d.epc     = {new_val[XW-1:2], 2'b00};
                SEL_CAUSE:   st_d.cause   = new_val;
                SEL_STEP:    st_d.step    = new_val[0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign glb_ie    = st_q.ie;
    assign ie_mask_o = st_q.ie_reg;
    assign tvec_o    = st_q.tvec;
    assign epc_o     = st_q.epc;
    assign step_en   = st_q.step;

    // R10
    trap_ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> !glb_ie && st_q.pie == $past(glb_ie) && epc_o == {$past(trap_pc[31:2]), 2'b00});

    // R11
    trap_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_return && !trap_enter |=> glb_ie == $past(st_q.pie) && st_q.pie);

    // R4
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en && csr_illegal && !trap_enter && !trap_return |=>
            $stable(st_q.scratch) && $stable(st_q.tvec) && $stable(st_q.ie_reg) &&
            $stable(st_q.ie) && $stable(st_q.step) && $stable(st_q.epc));

    // R2
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en && csr_op[1] && csr_src == 32'h0 |=>
            $stable(st_q.scratch) && $stable(st_q.tvec) && $stable(st_q.ie_reg) && $stable(st_q.step));

    // R9
    epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epc_o[1:0] == 2'b00);

    // R12
    pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_q.pend == ($past(irq_lines) & IRQ_MASK));
endmodule

// File: tb/mcsr_bank_bench.sv
module mcsr_bank_bench;
    localparam logic [63:0] CYC_INIT = 64'h0000_0000_FFFF_FFF0;
    localparam logic [31:0] MASK     = 32'hFFFF_0888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 1'b0;
    logic        csr_en = 1'b0;
    logic [1:0]  csr_op = 2'b00;
    logic [11:0] csr_addr = 12'h0;
    logic [31:0] csr_src = 32'h0;
    logic        trap_enter = 1'b0, trap_return = 1'b0;
    logic [31:0] trap_cause = 32'h0, trap_pc = 32'h0, irq_lines = 32'h0;
    logic [31:0] csr_rdata, ie_mask_o, tvec_o, epc_o;
    logic        csr_illegal, glb_ie, step_en;
    logic [31:0] n_rdata, n_ie_mask, n_tvec, n_epc;
    logic        n_illegal, n_ie, n_step;

    int errors = 0;
    int checks = 0;

    // Reference state
    bit          m_ie, m_pie, m_step;
    logic [31:0] m_iereg, m_tvec, m_scratch, m_epc, m_cause, m_pend;
    logic [63:0] m_cyc;

    always #2 clk = ~clk;

    mcsr_bank #(.CYC_RESET(CYC_INIT)) u_mcsr_bank (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_src(csr_src), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .trap_enter(trap_enter), .trap_return(trap_return),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .irq_lines(irq_lines),
        .glb_ie(glb_ie), .ie_mask_o(ie_mask_o), .tvec_o(tvec_o), .epc_o(epc_o),
        .step_en(step_en)
    );

    mcsr_bank #(.HAS_MUL(1'b0), .CYC_RESET(CYC_INIT)) u_mcsr_bank_nomul (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_src(csr_src), .csr_rdata(n_rdata),
        .csr_illegal(n_illegal), .trap_enter(trap_enter), .trap_return(trap_return),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .irq_lines(irq_lines),
        .glb_ie(n_ie), .ie_mask_o(n_ie_mask), .tvec_o(n_tvec), .epc_o(n_epc),
        .step_en(n_step)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic void model_read(input logic [11:0] a, output logic [31:0] v,
                                       output bit known, output bit ro);
        known = 1'b1; ro = 1'b0; v = 32'h0;
        case (a)
            12'h300: v = 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
            12'h301: begin v = 32'h4000_1100; ro = 1'b1; end
            12'h304: v = m_iereg;
            12'h305: v = m_tvec;
            12'h311, 12'h312, 12'h314: ro = 1'b1;
            12'h313: begin v = 32'h0001_0014; ro = 1'b1; end
            12'h340: v = m_scratch;
            12'h341: v = m_epc;
            12'h342: v = m_cause;
            12'h344: begin v = m_pend; ro = 1'b1; end
            12'h7C0: v = {31'b0, m_step};
            12'hB00: begin v = m_cyc[31:0];  ro = 1'b1; end
            12'hB80: begin v = m_cyc[63:32]; ro = 1'b1; end
            default: known = 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_ie = 0; m_pie = 0; m_step = 0;
        m_iereg = 0; m_tvec = 0; m_scratch = 0; m_epc = 0; m_cause = 0; m_pend = 0;
        m_cyc = CYC_INIT;
    endtask

    // One clock: drive at falling edge, compare before rising edge, then advance model.
    task automatic cyc(input string req, input bit en, input logic [1:0] op, input logic [11:0] a,
                       input logic [31:0] src, input bit te = 0, input bit tr = 0,
                       input logic [31:0] cause = 0, input logic [31:0] pc = 0,
                       input logic [31:0] irq = 0);
        logic [31:0] cur, nv;
        bit known, ro, wr, ill;
        @(negedge clk);
        rst_n = rst_req; csr_en = en; csr_op = op; csr_addr = a; csr_src = src;
        trap_enter = te; trap_return = tr; trap_cause = cause; trap_pc = pc; irq_lines = irq;
        #1;
        model_read(a, cur, known, ro);
        case (op)
            2'b00: begin nv = cur; wr = 0; end
            2'b01: begin nv = src; wr = 1; end
            2'b10: begin nv = cur | src; wr = (src != 0); end
            default: begin nv = cur & ~src; wr = (src != 0); end
        endcase
        ill = en && (!known || (ro && wr));
        if (en && known) chk(req, "rdata", csr_rdata, cur);
        if (en && a == 12'h301) chk("R6", "nomul isa", n_rdata, 32'h4000_0100);
        chk(req, "illegal", {31'b0, csr_illegal}, {31'b0, ill});
        chk(req, "glb_ie", {31'b0, glb_ie}, {31'b0, m_ie});
        chk(req, "ie_mask", ie_mask_o, m_iereg);
        chk(req, "tvec", tvec_o, m_tvec);
        chk(req, "epc", epc_o, m_epc);
        chk(req, "step_en", {31'b0, step_en}, {31'b0, m_step});
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            if (te) begin
                m_epc = pc & ~32'h3; m_cause = cause; m_pie = m_ie; m_ie = 0;
            end else if (tr) begin
                m_ie = m_pie; m_pie = 1;
            end else if (en && wr && !ill) begin
                case (a)
                    12'h300: begin m_ie = nv[3]; m_pie = nv[7]; end
                    12'h304: m_iereg = nv & MASK;
                    12'h305: m_tvec = nv;
                    12'h340: m_scratch = nv;
                    12'h341: m_epc = nv & ~32'h3;
                    12'h342: m_cause = nv;
                    12'h7C0: m_step = nv[0];
                    default: ;
                endcase
            end
            m_pend = irq & MASK;
            m_cyc  = m_cyc + 1;
        end
    endtask

    initial begin
        logic [11:0] addrs [18];
        addrs = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h311, 12'h312, 12'h313, 12'h314,
                  12'h340, 12'h341, 12'h342, 12'h344, 12'h7C0, 12'hB00, 12'hB80,
                  12'h123, 12'h7C1, 12'hB01};
        model_reset();
        // R1: reset state
        rst_req = 0;
        cyc("R1", 1, 2'b00, 12'h300, 0);
        cyc("R1", 1, 2'b00, 12'hB00, 0);
        cyc("R1", 1, 2'b00, 12'hB80, 0);
        cyc("R1", 1, 2'b00, 12'h7C0, 0);
        rst_req = 1;
        // R13: counter carry from low word into high word
        for (int i = 0; i < 12; i++) begin
            cyc("R13", 1, 2'b00, 12'hB00, 0);
            cyc("R13", 1, 2'b00, 12'hB80, 0);
        end
        // R6 / R7: identification
        cyc("R6", 1, 2'b00, 12'h301, 0);
        cyc("R7", 1, 2'b00, 12'h311, 0);
        cyc("R7", 1, 2'b00, 12'h312, 0);
        cyc("R7", 1, 2'b00, 12'h313, 0);
        cyc("R7", 1, 2'b00, 12'h314, 0);
        // R2 / R3: operation codes on scratch
        cyc("R2", 1, 2'b01, 12'h340, 32'hDEAD_BEEF);
        cyc("R3", 1, 2'b00, 12'h340, 0);
        cyc("R2", 1, 2'b11, 12'h340, 32'h0000_00FF);
        cyc("R2", 1, 2'b10, 12'h340, 32'h0000_0F00);
        cyc("R2", 1, 2'b10, 12'h340, 32'h0);
        cyc("R2", 1, 2'b11, 12'h340, 32'h0);
        cyc("R2", 1, 2'b00, 12'h340, 0);
        // R4: read-only and unmapped
        cyc("R4", 1, 2'b10, 12'h301, 32'h0);
        cyc("R4", 1, 2'b01, 12'h301, 32'h1);
        cyc("R4", 1, 2'b11, 12'hB00, 32'h5);
        cyc("R4", 1, 2'b00, 12'h123, 0);
        cyc("R4", 1, 2'b01, 12'h7C1, 32'h1);
        // R5 status
        cyc("R5", 1, 2'b01, 12'h300, 32'hFFFF_FFFF);
        cyc("R5", 1, 2'b00, 12'h300, 0);
        cyc("R5", 1, 2'b11, 12'h300, 32'h8);
        cyc("R5", 1, 2'b00, 12'h300, 0);
        cyc("R5", 1, 2'b10, 12'h300, 32'h8);
        // R8 enable mask
        cyc("R8", 1, 2'b01, 12'h304, 32'hFFFF_FFFF);
        cyc("R8", 1, 2'b00, 12'h304, 0);
        // R9 epc alignment
        cyc("R9", 1, 2'b01, 12'h341, 32'h0000_1237);
        cyc("R9", 1, 2'b00, 12'h341, 0);
        // R10 trap entry overrides a write
        cyc("R10", 1, 2'b01, 12'h340, 32'h1111_1111, 1, 0, 32'hB, 32'h2003);
        cyc("R10", 1, 2'b00, 12'h342, 0);
        cyc("R10", 1, 2'b00, 12'h341, 0);
        cyc("R10", 1, 2'b00, 12'h300, 0);
        // R11 trap return overrides a write
        cyc("R11", 1, 2'b01, 12'h305, 32'hAAAA_0000, 0, 1);
        cyc("R11", 1, 2'b00, 12'h300, 0);
        cyc("R10", 1, 2'b00, 12'h300, 0, 1, 1, 32'h8000_000B, 32'h4000);
        cyc("R10", 1, 2'b00, 12'h300, 0);
        // R12 pending
        cyc("R12", 1, 2'b00, 12'h344, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
        cyc("R12", 1, 2'b00, 12'h344, 0, 0, 0, 0, 0, 32'h0000_0801);
        cyc("R12", 1, 2'b00, 12'h344, 0);
        // R14 step and full-width registers
        cyc("R14", 1, 2'b01, 12'h7C0, 32'hFFFF_FFFF);
        cyc("R14", 1, 2'b00, 12'h7C0, 0);
        cyc("R14", 1, 2'b01, 12'h305, 32'h8765_4321);
        cyc("R14", 1, 2'b11, 12'h7C0, 32'h1);
        // Mixed sweep
        for (int i = 0; i < 400; i++) begin
            int k = int'($urandom_range(0, 17));
            logic [31:0] s = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            bit te = ($urandom_range(0, 15) == 0);
            bit tr = !te && ($urandom_range(0, 15) == 0);
            cyc("R3", 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), addrs[k], s,
                te, tr, $urandom, $urandom, $urandom);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule